// File: doc/BRIEF.md
# Burst Address Counter

This block holds the address that one port of a synchronous memory uses in each cycle. Three active-low controls are sampled at every rising edge of the port clock, and they act in a fixed order of precedence. A clear forces the address to zero. Otherwise a strobe loads the address presented on the external bus. Otherwise an advance request steps the held address up by one. If none of these is asserted, the held address is reused. A host can therefore start a burst with one strobe and walk through consecutive words without driving the bus again.

The new address appears on the output right after the edge that chose it, so the memory array uses it during that same cycle. The block takes no chip-enable or byte-select inputs. Clearing, loading and stepping all take place whether or not the port is selected for a transfer. There are no data or stream interfaces; every pin is a plain level signal.

Top module: `burst_addr_ctr`

## Requirements
- R1: When `clr_n` is low at a rising edge, `addr` is 0 after that edge, whatever `ld_n`, `adv_n` and `ext_addr` are.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `addr` equals the `ext_addr` value sampled at that edge, whatever `adv_n` is.
- R3: When `clr_n`, `ld_n` and `adv_n` are all high at a rising edge, `addr` keeps its previous value and `ext_addr` has no effect.
- R4: When `clr_n` and `ld_n` are high and `adv_n` is low at a rising edge, `addr` becomes its previous value plus one.
- R5: Stepping from the largest address (all ones, 16383 at the default width of 14 bits) wraps `addr` to 0.
- R6: Before the first clock edge, `addr` reads 0.
- R7: The precedence is fixed as clear, then load, then advance, then hold. A lower-ranked control never changes the result while a higher-ranked one is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all decisions are taken at its rising edge |
| clr_n | input | 1 | Synchronous clear to address 0, active low, highest precedence |
| ld_n | input | 1 | Address strobe, active low: load `ext_addr` |
| adv_n | input | 1 | Advance request, active low: step the held address by one |
| ext_addr | input | ADDR_W (14) | External address, used only on a load |
| addr | output | ADDR_W (14) | Address used by the memory array in the current cycle |

## Verification
The bench keeps its own integer model of the address and compares it with `addr` after every edge. Directed phases cover the following cases:
- a clear asserted together with a strobe and an advance, which a design with the wrong precedence would answer with the external address or an increment;
- a strobe asserted together with an advance, which a faulty design would resolve by stepping past the loaded value;
- a hold while `ext_addr` toggles, which catches a design that leaks the external bus into the held value;
- an advance from the top address, which a design with a wider or saturating adder would turn into a stuck or truncated value instead of 0.

Random control mixes then run for several thousand cycles to reach interleavings that the directed phases do not cover.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } addr_act_e;
endpackage

// File: rtl/burst_addr_arb.sv
module burst_addr_arb
  import burst_addr_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      adv_n,
  output addr_act_e act
);
  // Fixed precedence: clear, load, step, hold
  always_comb begin
    if (!clr_n)      act = ACT_CLEAR;
    else if (!ld_n)  act = ACT_LOAD;
    else if (!adv_n) act = ACT_STEP;
    else             act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  addr_act_e         act,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = ext;
      ACT_STEP:  nxt = cur + ONE;  // natural wrap at the top address
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  addr_act_e         act;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] addr_q = '0;   // powers up at zero
  logic              primed = 1'b0; // set once an edge has been seen

  burst_addr_arb u_arb (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .adv_n (adv_n),
    .act   (act)
  );

  burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .act (act),
    .cur (addr_q),
    .ext (ext_addr),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    addr_q <= nxt;
    primed <= 1'b1;
  end

  assign addr = addr_q;

  // Checks tied to the requirements, sampled at each edge
  assert_clear_wins_R1: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> (addr == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !ld_n) |=> (addr == $past(ext_addr)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && adv_n) |=> $stable(addr));

  assert_step_R4: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && !adv_n) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && !adv_n && addr == TOP_ADDR) |=> (addr == '0));

  always_comb begin
    if (!primed) assert_powerup_R6: assert (addr == '0);
  end
endmodule

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;
  localparam int W = 14;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic         ld_n = 1'b1;
  logic         adv_n = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic [W-1:0] addr;

  int model = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  burst_addr_ctr #(.ADDR_W(W)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
    .ext_addr(ext_addr), .addr(addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: addr=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, update the model at the rising
  // edge, compare 1 ns later.
  task automatic step(input bit c, input bit l, input bit a, input int e);
    string req;
    @(negedge clk);
    clr_n = c; ld_n = l; adv_n = a; ext_addr = W'(e);
    @(posedge clk);
    if (!c) begin
      model = 0; req = (!l || !a) ? "R7/R1" : "R1";
    end else if (!l) begin
      model = e; req = !a ? "R7/R2" : "R2";
    end else if (!a) begin
      req = (model == TOP) ? "R5" : "R4";
      model = (model + 1) % (TOP + 1);
    end else begin
      req = "R3";
    end
    #1;
    check(req, int'(addr), model);
  endtask

  initial begin
    #1;
    check("R6", int'(addr), 0);  // power-up value, before any edge

    step(0, 1, 1, 0);                // R1 plain clear
    step(1, 0, 1, 100);              // R2 load
    step(1, 1, 0, 9999);             // R4 step, ext ignored
    step(1, 1, 0, 0);                // R4
    for (int i = 0; i < 4; i++)      // R3 hold while bus toggles
      step(1, 1, 1, (i * 4099) & TOP);
    step(0, 0, 0, 555);              // R7/R1 clear beats load and step
    step(1, 0, 0, 777);              // R7/R2 load beats step
    step(1, 0, 1, TOP - 1);          // R2 near top
    step(1, 1, 0, 3);                // R4 to top
    step(1, 1, 0, 3);                // R5 wrap to 0
    step(1, 1, 0, 3);                // R4 after wrap
    step(1, 0, 0, TOP);              // R7 load top with step asserted
    step(1, 1, 0, 0);                // R5 wrap again
    step(0, 1, 0, 0);                // R1 clear beats step

    for (int i = 0; i < 5000; i++)
      step(($urandom % 16) != 0, ($urandom % 6) != 0,
           ($urandom % 3) == 0, int'($urandom % (TOP + 1)));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule